// File: doc/BRIEF.md
# Threshold-Flagged Saturating Event Counter

This block keeps a running count of hardware events. Two single-cycle strobes move the count: one steps it up and one steps it down. Two comparators run against the current count and each raises a flag: one when the count has climbed to a programmable upper mark, and one when it has fallen to a programmable lower mark. A synchronous clear input returns the counter to its starting point.

A build parameter picks one of two modes. In wrap mode the count rolls over at either end of its range. A one-cycle overflow or underflow pulse marks the cycle in which the roll-over strobe is presented. In saturating mode the count is clamped between two build-time limits. Strobes that would push it past a limit leave it where it is. A sticky saturation flag records that a limit was reached, and the wrap pulses never fire. Typical uses are event tallies, credit trackers and fill-level monitors, where a neighbouring block reacts to the flags.

Top module: `evctr_top`

## Requirements
- R1: While reset is asserted and after it is released, the count is 0, the saturation flag is 0 and both wrap pulses are 0.
- R2: A cycle with the up strobe high, the down strobe low and clear low raises the count by one at the next clock edge, unless saturating mode holds it (R9).
- R3: A cycle with the down strobe high, the up strobe low and clear low lowers the count by one at the next clock edge, unless saturating mode holds it (R9).
- R4: A cycle with both strobes high, or with both strobes low, leaves the count unchanged.
- R5: The upper-mark flag is high exactly while the registered count is greater than or equal to the upper threshold input, compared as unsigned values.
- R6: The lower-mark flag is high exactly while the registered count is less than or equal to the lower threshold input, compared as unsigned values.
- R7: In wrap mode, an up step taken from the all-ones count gives 0. The overflow pulse is high only in the cycle where the up step is presented at the all-ones count.
- R8: In wrap mode, a down step taken from 0 gives the all-ones count. The underflow pulse is high only in the cycle where the down step is presented at 0.
- R9: In saturating mode, an up step at or above the upper limit leaves the count unchanged. A down step at or below the lower limit also leaves the count unchanged.
- R10: In saturating mode, the saturation flag goes high at the clock edge after an up step whose result is at or above the upper limit. It also goes high after a down step whose result is at or below the lower limit. The flag then stays high until a clear, and the overflow and underflow pulses stay 0. In wrap mode the flag stays 0.
- R11: Clear takes priority over both strobes. At the next clock edge the count becomes 0 and the saturation flag becomes 0, and no wrap pulse fires in the clear cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of count and saturation flag |
| inc | input | 1 | Up-step strobe |
| dec | input | 1 | Down-step strobe |
| up_thr | input | W | Upper threshold for the upper-mark flag |
| dn_thr | input | W | Lower threshold for the lower-mark flag |
| count | output | W | Registered count value |
| up_hit | output | 1 | Count is at or above up_thr |
| dn_hit | output | 1 | Count is at or below dn_thr |
| ovf_pulse | output | 1 | Wrap-mode overflow marker, same cycle as the up step |
| unf_pulse | output | 1 | Wrap-mode underflow marker, same cycle as the down step |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The embedded properties check these relations on every cycle:
- single steps move the count by exactly one;
- balanced or idle strobes leave the count stable;
- a wrap pulse is followed by the rolled-over value, and the two pulses never fire together;
- in saturating mode the count holds at a limit, and the saturation flag is sticky;
- clear zeroes the state.

Only the bench scenarios can show the threshold flags tracking changing threshold inputs, and the exact cycle in which each pulse appears. They also show where the flag rises when the count lands on a limit rather than crossing it, and how the wrap and saturating modes differ under identical stimulus.

// File: rtl/evctr_pkg.sv
package evctr_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } dir_e;

  // Clear wins, balanced or absent strobes hold, otherwise the lone strobe decides.
  function automatic dir_e pick_dir(input logic clr, input logic inc, input logic dec);
    if (clr || (inc == dec)) return DIR_HOLD;
    if (inc)                 return DIR_UP;
    return DIR_DN;
  endfunction

endpackage

// File: rtl/evctr_step.sv
module evctr_step
  import evctr_pkg::*;
#(
  parameter int            W       = 4,
  parameter bit            SAT_EN  = 1'b0,
  parameter logic [W-1:0]  SAT_MAX = '1,
  parameter logic [W-1:0]  SAT_MIN = '0
) (
  input  logic [W-1:0] cur,
  input  dir_e         dir,
  output logic [W-1:0] nxt,
  output logic         wrap_up,
  output logic         wrap_dn,
  output logic         at_limit
);

  localparam logic [W-1:0] TOP_VAL = '1;
  localparam logic [W-1:0] BOT_VAL = '0;

  function automatic logic [W-1:0] step_up(input logic [W-1:0] c);
    if (SAT_EN && (c >= SAT_MAX)) return c;
    return c + 1'b1;
  endfunction

  function automatic logic [W-1:0] step_dn(input logic [W-1:0] c);
    if (SAT_EN && (c <= SAT_MIN)) return c;
    return c - 1'b1;
  endfunction

  always_comb begin
    case (dir)
      DIR_UP:  nxt = step_up(cur);
      DIR_DN:  nxt = step_dn(cur);
      default: nxt = cur;
    endcase
  end

  generate
    if (SAT_EN) begin : g_sat
      assign wrap_up  = 1'b0;
      assign wrap_dn  = 1'b0;
      assign at_limit = ((dir == DIR_UP) && (nxt >= SAT_MAX)) ||
                        ((dir == DIR_DN) && (nxt <= SAT_MIN));
    end else begin : g_wrap
      assign wrap_up  = (dir == DIR_UP) && (cur == TOP_VAL);
      assign wrap_dn  = (dir == DIR_DN) && (cur == BOT_VAL);
      assign at_limit = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/evctr_cmp.sv
module evctr_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] hi_mark,
  input  logic [W-1:0] lo_mark,
  output logic         at_or_above,
  output logic         at_or_below
);

  function automatic logic ge_u(input logic [W-1:0] a, input logic [W-1:0] b);
    return a >= b;
  endfunction

  assign at_or_above = ge_u(value, hi_mark);
  assign at_or_below = ge_u(lo_mark, value);

endmodule

// File: rtl/evctr_satflag.sv
module evctr_satflag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (hit) flag <= 1'b1;
  end

  // R10: once raised the flag only drops through clear
  p_sat_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  // R11: clear drops the flag
  p_sat_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);

endmodule

// File: rtl/evctr_top.sv
module evctr_top
  import evctr_pkg::*;
#(
  parameter int            W       = 4,
  parameter bit            SAT_EN  = 1'b0,
  parameter logic [W-1:0]  SAT_MAX = '1,
  parameter logic [W-1:0]  SAT_MIN = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         dec,
  input  logic [W-1:0] up_thr,
  input  logic [W-1:0] dn_thr,
  output logic [W-1:0] count,
  output logic         up_hit,
  output logic         dn_hit,
  output logic         ovf_pulse,
  output logic         unf_pulse,
  output logic         sat_flag
);

  localparam logic [W-1:0] TOP_VAL = '1;

  dir_e         step_dir;
  logic [W-1:0] next_count;
  logic         ev_wrap_up;
  logic         ev_wrap_dn;
  logic         ev_at_limit;

  assign step_dir = pick_dir(clr, inc, dec);

  evctr_step #(
    .W(W), .SAT_EN(SAT_EN), .SAT_MAX(SAT_MAX), .SAT_MIN(SAT_MIN)
  ) u_step (
    .cur      (count),
    .dir      (step_dir),
    .nxt      (next_count),
    .wrap_up  (ev_wrap_up),
    .wrap_dn  (ev_wrap_dn),
    .at_limit (ev_at_limit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= next_count;
  end

  evctr_cmp #(.W(W)) u_cmp (
    .value       (count),
    .hi_mark     (up_thr),
    .lo_mark     (dn_thr),
    .at_or_above (up_hit),
    .at_or_below (dn_hit)
  );

  evctr_satflag u_sat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .hit   (ev_at_limit),
    .flag  (sat_flag)
  );

  assign ovf_pulse = ev_wrap_up;
  assign unf_pulse = ev_wrap_dn;

  // R2: a lone up step not held by a limit moves the count up by one
  p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && !dec && !(SAT_EN && (count >= SAT_MAX)))
      |=> count == W'($past(count) + 1'b1));

  // R3: a lone down step not held by a limit moves the count down by one
  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && dec && !inc && !(SAT_EN && (count <= SAT_MIN)))
      |=> count == W'($past(count) - 1'b1));

  // R4: balanced or idle strobes hold the count
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (inc == dec)) |=> $stable(count));

  // R7: overflow is followed by a zero count
  p_ovf_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> count == '0);

  // R8: underflow is followed by the all-ones count
  p_unf_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unf_pulse |=> count == TOP_VAL);

  // R8: the two wrap markers never coincide
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_pulse, unf_pulse}));

  // R9: an up step at the upper limit holds the count
  p_sat_hold_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (SAT_EN && !clr && inc && !dec && (count >= SAT_MAX)) |=> $stable(count));

  // R9: a down step at the lower limit holds the count
  p_sat_hold_dn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (SAT_EN && !clr && dec && !inc && (count <= SAT_MIN)) |=> $stable(count));

  // R11: clear zeroes the count
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

endmodule

// File: tb/sim_evctr_top.sv
module sim_evctr_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, inc = 1'b0, dec = 1'b0;
  logic [3:0] up_thr = 4'd6, dn_thr = 4'd2;

  logic [3:0] cnt_w, cnt_s;
  logic       uph_w, dnh_w, ovf_w, unf_w, sat_w;
  logic       uph_s, dnh_s, ovf_s, unf_s, sat_s;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  evctr_top #(.W(4), .SAT_EN(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .dec(dec),
    .up_thr(up_thr), .dn_thr(dn_thr), .count(cnt_w), .up_hit(uph_w),
    .dn_hit(dnh_w), .ovf_pulse(ovf_w), .unf_pulse(unf_w), .sat_flag(sat_w));

  evctr_top #(.W(4), .SAT_EN(1'b1), .SAT_MAX(4'd12), .SAT_MIN(4'd3)) u1 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .dec(dec),
    .up_thr(up_thr), .dn_thr(dn_thr), .count(cnt_s), .up_hit(uph_s),
    .dn_hit(dnh_s), .ovf_pulse(ovf_s), .unf_pulse(unf_s), .sat_flag(sat_s));

  typedef struct {
    string      tag;
    logic [3:0] cw;
    logic       upw, dnw, ow, uw, sw;
    logic [3:0] cs;
    logic       ups, dns, os, us, ss;
  } exp_t;

  exp_t q[$];

  // reference state, independent of the design
  logic [3:0] mw = 4'd0, ms = 4'd0;
  logic       msat = 1'b0;
  logic [3:0] nu = 4'd6, nd = 4'd2;

  task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive(input string tag, input logic i, input logic d, input logic c, input int n);
    exp_t e;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inc = i; dec = d; clr = c; up_thr = nu; dn_thr = nd;
      e.tag = tag;
      e.cw  = mw;
      e.upw = (mw >= nu);
      e.dnw = (mw <= nd);
      e.ow  = i && !d && !c && (mw == 4'd15);
      e.uw  = d && !i && !c && (mw == 4'd0);
      e.sw  = 1'b0;
      e.cs  = ms;
      e.ups = (ms >= nu);
      e.dns = (ms <= nd);
      e.os  = 1'b0;
      e.us  = 1'b0;
      e.ss  = msat;
      q.push_back(e);
      if (c) begin
        mw = 4'd0; ms = 4'd0; msat = 1'b0;
      end else if (i && !d) begin
        mw = mw + 4'd1;
        if (ms < 4'd12) ms = ms + 4'd1;
        if (ms >= 4'd12) msat = 1'b1;
      end else if (d && !i) begin
        mw = mw - 4'd1;
        if (ms > 4'd3) ms = ms - 4'd1;
        if (ms <= 4'd3) msat = 1'b1;
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor: compare half a phase after the driver, before the next rising edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "wrap count", cnt_w, e.cw);
        chk(e.tag, "wrap up_hit", {3'b0, uph_w}, {3'b0, e.upw});
        chk(e.tag, "wrap dn_hit", {3'b0, dnh_w}, {3'b0, e.dnw});
        chk(e.tag, "wrap ovf", {3'b0, ovf_w}, {3'b0, e.ow});
        chk(e.tag, "wrap unf", {3'b0, unf_w}, {3'b0, e.uw});
        chk(e.tag, "wrap sat_flag", {3'b0, sat_w}, {3'b0, e.sw});
        chk(e.tag, "sat count", cnt_s, e.cs);
        chk(e.tag, "sat up_hit", {3'b0, uph_s}, {3'b0, e.ups});
        chk(e.tag, "sat dn_hit", {3'b0, dnh_s}, {3'b0, e.dns});
        chk(e.tag, "sat ovf", {3'b0, ovf_s}, {3'b0, e.os});
        chk(e.tag, "sat unf", {3'b0, unf_s}, {3'b0, e.us});
        chk(e.tag, "sat flag", {3'b0, sat_s}, {3'b0, e.ss});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    // R1: state while reset is held
    chk("R1", "count in reset", cnt_w, 4'd0);
    chk("R1", "sat flag in reset", {3'b0, sat_s}, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive("R1", 1'b0, 1'b0, 1'b0, 2);
    drive("R2 R5", 1'b1, 1'b0, 1'b0, 7);
    drive("R4 both", 1'b1, 1'b1, 1'b0, 3);
    drive("R4 idle", 1'b0, 1'b0, 1'b0, 2);
    drive("R3 R6", 1'b0, 1'b1, 1'b0, 6);
    drive("R8 R9", 1'b0, 1'b1, 1'b0, 3);
    drive("R7 R9 R10", 1'b1, 1'b0, 1'b0, 20);
    drive("R11 clear over inc", 1'b1, 1'b0, 1'b1, 1);
    drive("R11 after clear", 1'b0, 1'b0, 1'b0, 2);
    nu = 4'd0; nd = 4'd15;
    drive("R5 R6 R8 R10", 1'b0, 1'b1, 1'b0, 2);
    drive("R10 sticky", 1'b1, 1'b0, 1'b0, 2);
    drive("R11 clear over dec", 1'b0, 1'b1, 1'b1, 1);
    drive("R11 idle", 1'b0, 1'b0, 1'b0, 2);
    @(negedge clk);
    inc = 1'b0; dec = 1'b0; clr = 1'b0;
    @(negedge clk);
    #10;
    summary();
    $finish;
  end

endmodule